// File: doc/BRIEF.md
# Triggered ADC Scan Sequencer

This controller runs a programmed scan of analog input channels. Each conversion waits for its own pulse on an active-low convert-start input. A command write sets several things at once: a bit mask of channels to visit, an averaging count, an optional temperature reading and a reference mode. While convert-start is low, the controller counts clocks of acquisition time. On the rising edge it issues a one-cycle start strobe and a channel code to an external converter model, then waits for the converter's done strobe.

Samples for one channel are summed in a wide accumulator. Once the averaging count is reached, the sum is shifted down and the result goes into a small result FIFO, and the channel select moves on to the next channel in the mask. A temperature reading, when requested, uses the first accepted trigger after the command and is stored without averaging. An active-low end-of-conversion flag drops after each finished conversion. A done flag rises once every expected conversion has completed. Two sticky flags report a trigger released too early and a FIFO write that was lost.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset no scan is active: `eocN`=1, `adcStart`=0, `scanDone`=0, `acqErr`=0, `ovfErr`=0 and `fifoEmpty`=1.
- R2: A cycle with `cmdValid`=1 loads a new scan and clears `acqErr`, `ovfErr`, `scanDone` and the partial average. From the next cycle `adcChan` shows the first conversion: code NCH (temperature) when `cmdTempEn`=1, otherwise the index of the lowest set bit of `cmdChanMask` (0 if the mask is empty).
- R3: A rising edge of `cnvStN` is accepted only if `cnvStN` was sampled low on at least a minimum number of clocks before it. The minimum is TEMP_CYC for a temperature conversion, ACQ_CYC+REF_CYC when `cmdRefMode` is 00 or 10, and ACQ_CYC otherwise. An accepted edge gives a one-cycle `adcStart` on the following cycle.
- R4: A rising edge that comes too early sets `acqErr`. No start is issued and the conversion does not count. `acqErr` stays set until the next command.
- R5: `eocN` goes low in the cycle after `adcDone` ends a conversion in progress. It returns high in the cycle after `csN` or `cnvStN` is sampled low.
- R6: `cmdAvgSel` encodes the averaging count: 0→1, 1→4, 2→8, 3→16, 4→32, and any other value→1. After that many conversions of one channel, the sum shifted right by log2(count) is written to the FIFO.
- R7: After an averaged write, `adcChan` moves to the next higher set bit of the mask. A temperature result is written unaveraged, before any channel result.
- R8: `scanDone` rises when the number of completed conversions reaches popcount(mask)×count, plus one if temperature is enabled. After that, further triggers start nothing.
- R9: The FIFO is first-in first-out. `fifoRdData` shows the oldest word while `fifoEmpty`=0, and `fifoRdEn` removes it.
- R10: A result produced while the FIFO holds FDEPTH words is dropped and sets `ovfErr`, which stays set until the next command.
- R11: A rising edge of `cnvStN` while a conversion is in progress is ignored: no start, no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Load a new scan command |
| cmdChanMask | input | NCH | Channels to scan |
| cmdAvgSel | input | 3 | Averaging count code |
| cmdTempEn | input | 1 | Temperature conversion first |
| cmdRefMode | input | 2 | Reference mode; 00 and 10 need reference warm-up |
| cnvStN | input | 1 | Active-low convert-start trigger |
| csN | input | 1 | Active-low chip select, releases end-of-conversion |
| adcStart | output | 1 | One-cycle start/sample strobe to converter |
| adcChan | output | $clog2(NCH+1) | Mux select; NCH selects temperature |
| adcDone | input | 1 | Converter result valid |
| adcData | input | DW | Converter result |
| eocN | output | 1 | Active-low end-of-conversion flag |
| scanDone | output | 1 | All programmed conversions finished |
| acqErr | output | 1 | Sticky early-trigger error |
| ovfErr | output | 1 | Sticky FIFO overflow |
| fifoRdEn | input | 1 | Pop oldest FIFO word |
| fifoRdData | output | DW | Oldest FIFO word |
| fifoEmpty | output | 1 | FIFO holds no word |

## Verification
The bench builds the block with NCH=4, FDEPTH=4, ACQ_CYC=6, REF_CYC=10 and TEMP_CYC=2. At these values the 1.4 µs and 45 µs acquisition windows shrink to a few clocks, so early and on-time triggers under both reference modes fit in short pulses. A four-channel scan fills the four-deep FIFO, which makes an overflow easy to reach. A full 32-sample average of one channel also stays well inside the run length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;   // new command: clear accumulator and overflow flag
    logic add;   // a conversion result is valid
    logic push;  // write a word into the FIFO
    logic raw;   // word is the raw sample (temperature)
  } dpStrobe_t;

  // log2 of the averaging count for each select code
  function automatic logic [2:0] avgShift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 3'd2;
      3'd2:    return 3'd3;
      3'd3:    return 3'd4;
      3'd4:    return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int ACQ_CYC  = 350,
  parameter int REF_CYC  = 11250,
  parameter int TEMP_CYC = 10,
  localparam int CHW     = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [NCH-1:0]   cmdChanMask,
  input  logic [2:0]       cmdAvgSel,
  input  logic             cmdTempEn,
  input  logic [1:0]       cmdRefMode,
  input  logic             cnvStN,
  input  logic             csN,
  input  logic             adcDone,
  output logic             adcStart,
  output logic [CHW-1:0]   adcChan,
  output logic             eocN,
  output logic             scanDone,
  output logic             acqErr,
  output dpStrobe_t        stb,
  output logic [2:0]       shiftAmt
);
  localparam int LW   = $clog2(NCH * 32 + 2);
  localparam int CNTW = $clog2(ACQ_CYC + REF_CYC + TEMP_CYC + 2) + 1;
  localparam logic [CNTW-1:0] LOW_MAX  = '1;
  localparam logic [CNTW-1:0] MIN_TEMP = CNTW'(TEMP_CYC);
  localparam logic [CNTW-1:0] MIN_ACQ  = CNTW'(ACQ_CYC);
  localparam logic [CNTW-1:0] MIN_REF  = CNTW'(ACQ_CYC + REF_CYC);

  function automatic logic [CHW-1:0] firstChan(input logic [NCH-1:0] m);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) r = CHW'(i);
    return r;
  endfunction

  function automatic logic [CHW-1:0] nextChan(input logic [NCH-1:0] m,
                                              input logic [CHW-1:0] cur);
    logic [CHW-1:0] r;
    logic hit;
    r = cur;
    hit = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (!hit && m[i] && (CHW'(i) > cur)) begin
        r = CHW'(i);
        hit = 1'b1;
      end
    return r;
  endfunction

  logic            prevCnv, busy, tempPh, needRef;
  logic [CNTW-1:0] lowCnt, minLow;
  logic [CHW-1:0]  chan;
  logic [5:0]      avgCnt;
  logic [LW-1:0]   left, totalCnt;
  logic [NCH-1:0]  maskR;
  logic            rise, accept, lenOk, doneEv, lastAvg;

  always_comb begin
    rise     = !prevCnv && cnvStN;
    accept   = rise && (left != '0) && !busy && !cmdValid;
    minLow   = tempPh ? MIN_TEMP : (needRef ? MIN_REF : MIN_ACQ);
    lenOk    = lowCnt >= minLow;
    doneEv   = adcDone && busy && !cmdValid;
    lastAvg  = avgCnt == 6'((1 << shiftAmt) - 1);
    totalCnt = LW'(($countones(cmdChanMask) << avgShift(cmdAvgSel)) + int'(cmdTempEn));
    stb.clr  = cmdValid;
    stb.add  = doneEv;
    stb.push = doneEv && (tempPh || lastAvg);
    stb.raw  = tempPh;
    adcChan  = tempPh ? CHW'(NCH) : chan;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCnv  <= 1'b1;
      lowCnt   <= '0;
      busy     <= 1'b0;
      tempPh   <= 1'b0;
      needRef  <= 1'b0;
      chan     <= '0;
      avgCnt   <= '0;
      left     <= '0;
      maskR    <= '0;
      shiftAmt <= '0;
      scanDone <= 1'b0;
      acqErr   <= 1'b0;
      eocN     <= 1'b1;
      adcStart <= 1'b0;
    end else begin
      prevCnv  <= cnvStN;
      lowCnt   <= cnvStN ? '0 : ((lowCnt == LOW_MAX) ? lowCnt : lowCnt + 1'b1);
      adcStart <= accept && lenOk;
      if (doneEv) eocN <= 1'b0;
      else if (!csN || !cnvStN) eocN <= 1'b1;

      if (cmdValid) begin
        maskR    <= cmdChanMask;
        shiftAmt <= avgShift(cmdAvgSel);
        needRef  <= (cmdRefMode == 2'b00) || (cmdRefMode == 2'b10);
        tempPh   <= cmdTempEn;
        chan     <= firstChan(cmdChanMask);
        avgCnt   <= '0;
        left     <= totalCnt;
        scanDone <= (totalCnt == '0);
        busy     <= 1'b0;
        acqErr   <= 1'b0;
      end else if (doneEv) begin
        busy     <= 1'b0;
        left     <= left - 1'b1;
        scanDone <= (left == LW'(1));
        if (tempPh) begin
          tempPh <= 1'b0;
        end else if (lastAvg) begin
          avgCnt <= '0;
          chan   <= nextChan(maskR, chan);
        end else begin
          avgCnt <= avgCnt + 1'b1;
        end
      end else if (accept) begin
        if (lenOk) busy <= 1'b1;
        else acqErr <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int DW     = 12,
  parameter int FDEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     stb,
  input  logic [2:0]    shiftAmt,
  input  logic [DW-1:0] adcData,
  input  logic          fifoRdEn,
  output logic [DW-1:0] fifoRdData,
  output logic          fifoEmpty,
  output logic          ovfErr
);
  localparam int AW = DW + 5;
  localparam int PW = (FDEPTH > 1) ? $clog2(FDEPTH) : 1;
  localparam int CW = $clog2(FDEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(FDEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(FDEPTH);

  logic [AW-1:0] acc, sumNext;
  logic [DW-1:0] word;
  logic [DW-1:0] mem [FDEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          full, wr, rd;

  always_comb begin
    sumNext    = acc + AW'(adcData);
    word       = stb.raw ? adcData : DW'(sumNext >> shiftAmt);
    full       = count == CNT_FULL;
    fifoEmpty  = count == '0;
    wr         = stb.push && !full;
    rd         = fifoRdEn && !fifoEmpty;
    fifoRdData = mem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      ovfErr <= 1'b0;
    end else if (stb.clr) begin
      acc    <= '0;
      ovfErr <= 1'b0;
    end else if (stb.add) begin
      acc <= stb.push ? '0 : sumNext;
      if (stb.push && full) ovfErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wr) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (rd) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(wr) - CW'(rd);
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wrPtr] <= word;
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int DW       = 12,
  parameter int FDEPTH   = 8,
  parameter int ACQ_CYC  = 350,
  parameter int REF_CYC  = 11250,
  parameter int TEMP_CYC = 10,
  localparam int CHW     = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdValid,
  input  logic [NCH-1:0] cmdChanMask,
  input  logic [2:0]     cmdAvgSel,
  input  logic           cmdTempEn,
  input  logic [1:0]     cmdRefMode,
  input  logic           cnvStN,
  input  logic           csN,
  output logic           adcStart,
  output logic [CHW-1:0] adcChan,
  input  logic           adcDone,
  input  logic [DW-1:0]  adcData,
  output logic           eocN,
  output logic           scanDone,
  output logic           acqErr,
  output logic           ovfErr,
  input  logic           fifoRdEn,
  output logic [DW-1:0]  fifoRdData,
  output logic           fifoEmpty
);
  dpStrobe_t  stb;
  logic [2:0] shiftAmt;

  adc_seq_ctrl #(
    .NCH(NCH), .ACQ_CYC(ACQ_CYC), .REF_CYC(REF_CYC), .TEMP_CYC(TEMP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdChanMask(cmdChanMask),
    .cmdAvgSel(cmdAvgSel), .cmdTempEn(cmdTempEn), .cmdRefMode(cmdRefMode),
    .cnvStN(cnvStN), .csN(csN), .adcDone(adcDone), .adcStart(adcStart),
    .adcChan(adcChan), .eocN(eocN), .scanDone(scanDone), .acqErr(acqErr),
    .stb(stb), .shiftAmt(shiftAmt)
  );

  adc_seq_dpath #(
    .DW(DW), .FDEPTH(FDEPTH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .shiftAmt(shiftAmt), .adcData(adcData),
    .fifoRdEn(fifoRdEn), .fifoRdData(fifoRdData), .fifoEmpty(fifoEmpty),
    .ovfErr(ovfErr)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic csN,
  input logic adcStart,
  input logic adcDone,
  input logic eocN,
  input logic scanDone,
  input logic acqErr,
  input logic ovfErr,
  input logic fifoEmpty
);
  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R5
  eoc_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !adcDone) |=> eocN);

  // R5
  eoc_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocN) |-> $past(adcDone));

  // R4
  acq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acqErr && !cmdValid) |=> acqErr);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfErr && !cmdValid) |=> ovfErr);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && !cmdValid) |=> !adcStart);

  // R9
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && !adcDone) |=> fifoEmpty);

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .csN(csN), .adcStart(adcStart),
  .adcDone(adcDone), .eocN(eocN), .scanDone(scanDone), .acqErr(acqErr),
  .ovfErr(ovfErr), .fifoEmpty(fifoEmpty)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  localparam int NCH = 4, DW = 12, FDEPTH = 4;
  localparam int ACQ = 6, REF = 10, TEMP = 2, CONV_LAT = 3;
  localparam int CHW = $clog2(NCH + 1);

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdTempEn = 0, cnvStN = 1, csN = 1, adcDone = 0, fifoRdEn = 0;
  logic [NCH-1:0] cmdChanMask = '0;
  logic [2:0] cmdAvgSel = '0;
  logic [1:0] cmdRefMode = '0;
  logic [DW-1:0] adcData = '0;
  logic adcStart, eocN, scanDone, acqErr, ovfErr, fifoEmpty;
  logic [CHW-1:0] adcChan;
  logic [DW-1:0] fifoRdData;

  always #2 clk = ~clk;

  adc_scan_seq #(.NCH(NCH), .DW(DW), .FDEPTH(FDEPTH), .ACQ_CYC(ACQ),
                 .REF_CYC(REF), .TEMP_CYC(TEMP)) uut (.*);

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter stub
  int stubCnt = 0, stubChan = 0, convIdx = 0;
  int logD[$];
  always @(negedge clk) begin
    adcDone <= 1'b0;
    if (rstN) begin
      if (stubCnt > 0) begin
        stubCnt--;
        if (stubCnt == 0) begin
          adcDone <= 1'b1;
          adcData <= DW'((stubChan * 517 + convIdx * 211 + 100) % 4096);
          logD.push_back((stubChan * 517 + convIdx * 211 + 100) % 4096);
          convIdx++;
        end
      end
      if (adcStart) begin
        stubCnt = CONV_LAT;
        stubChan = int'(adcChan);
      end
    end
  end

  // behavioural reference model
  function automatic int shiftOf(int sel);
    case (sel) 1: return 2; 2: return 3; 3: return 4; 4: return 5; default: return 0; endcase
  endfunction
  function automatic int firstOf(int m);
    for (int i = 0; i < NCH; i++) if (m[i]) return i;
    return 0;
  endfunction
  function automatic int nextOf(int m, int cur);
    for (int i = cur + 1; i < NCH; i++) if (m[i]) return i;
    return cur;
  endfunction

  int q[$];
  int mPrev, mLow, mBusy, mTemp, mChan, mAvg, mAcc, mLeft, mDone, mAcqErr, mOvf, mEoc, mStart;
  int mMask, mShift, mRef;
  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = 1; mLow = 0; mBusy = 0; mTemp = 0; mChan = 0; mAvg = 0; mAcc = 0;
      mLeft = 0; mDone = 0; mAcqErr = 0; mOvf = 0; mEoc = 1; mStart = 0;
      mMask = 0; mShift = 0; mRef = 0; q.delete();
    end else begin
      bit rise, doneEv, startN, push;
      int oldSize, minLow, res, pc;
      rise = !mPrev[0] && cnvStN;
      oldSize = q.size();
      startN = 0;
      push = 0;
      res = 0;
      doneEv = adcDone && (mBusy != 0) && !cmdValid;
      if (fifoRdEn && oldSize > 0) void'(q.pop_front());
      if (cmdValid) begin
        pc = 0;
        for (int i = 0; i < NCH; i++) if (cmdChanMask[i]) pc++;
        mMask = int'(cmdChanMask); mShift = shiftOf(int'(cmdAvgSel));
        mRef = int'(cmdRefMode); mTemp = int'(cmdTempEn);
        mLeft = (pc << mShift) + mTemp; mDone = (mLeft == 0);
        mChan = firstOf(mMask); mAvg = 0; mAcc = 0; mBusy = 0; mAcqErr = 0; mOvf = 0;
      end else if (doneEv) begin
        mBusy = 0; mLeft--; mDone = (mLeft == 0);
        if (mTemp != 0) begin res = int'(adcData); push = 1; mTemp = 0; end
        else begin
          mAcc += int'(adcData); mAvg++;
          if (mAvg == (1 << mShift)) begin
            res = mAcc >> mShift; push = 1; mAcc = 0; mAvg = 0; mChan = nextOf(mMask, mChan);
          end
        end
        if (push) begin
          if (oldSize < FDEPTH) q.push_back(res); else mOvf = 1;
        end
      end else if (rise && mLeft > 0 && mBusy == 0) begin
        minLow = (mTemp != 0) ? TEMP : (((mRef & 1) != 0) ? ACQ : ACQ + REF);
        if (mLow >= minLow) begin startN = 1; mBusy = 1; end else mAcqErr = 1;
      end
      if (doneEv) mEoc = 0; else if (!csN || !cnvStN) mEoc = 1;
      mLow = cnvStN ? 0 : mLow + 1;
      mPrev = int'(cnvStN);
      mStart = int'(startN);
    end
  end

  // every-clock comparison
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 R11 adcStart", int'(adcStart), mStart);
      chk("R7 adcChan", int'(adcChan), (mTemp != 0) ? NCH : mChan);
      chk("R5 eocN", int'(eocN), mEoc);
      chk("R8 scanDone", int'(scanDone), mDone);
      chk("R4 acqErr", int'(acqErr), mAcqErr);
      chk("R10 ovfErr", int'(ovfErr), mOvf);
      chk("R9 fifoEmpty", int'(fifoEmpty), (q.size() == 0) ? 1 : 0);
      if (q.size() > 0) chk("R6 R9 fifoRdData", int'(fifoRdData), q[0]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      finished = 1;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic doCmd(int mask, int sel, int temp, int refm);
    @(negedge clk);
    cmdValid = 1; cmdChanMask = NCH'(mask); cmdAvgSel = 3'(sel);
    cmdTempEn = temp[0]; cmdRefMode = 2'(refm);
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic pulse(int lowCyc, int waitCyc);
    cnvStN = 0;
    repeat (lowCyc) @(negedge clk);
    cnvStN = 1;
    repeat (waitCyc) @(negedge clk);
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (fifoEmpty) begin fifoRdEn = 0; break; end
      fifoRdEn = 1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state (still in reset)
    chk("R1 eocN", int'(eocN), 1);
    chk("R1 adcStart", int'(adcStart), 0);
    chk("R1 scanDone", int'(scanDone), 0);
    chk("R1 fifoEmpty", int'(fifoEmpty), 1);
    chk("R1 acqErr", int'(acqErr), 0);
    chk("R1 ovfErr", int'(ovfErr), 0);
    rstN = 1;
    @(negedge clk);

    // temperature + channels 1,2, no averaging, short acquisition
    doCmd(4'b0110, 0, 1, 1);
    chk("R2 first code temperature", int'(adcChan), NCH);
    pulse(TEMP, 8);
    pulse(ACQ, 8);
    pulse(ACQ, 8);
    pulse(ACQ, 8);          // beyond total: ignored (R8)
    chk("R8 done after three", int'(scanDone), 1);
    drain();

    // channels 0,1,3 averaged by 4 with reference warm-up
    logD.delete();
    doCmd(4'b1011, 1, 0, 0);
    chk("R2 first code channel", int'(adcChan), 0);
    pulse(ACQ + REF - 1, 8); // too early (R4)
    chk("R4 early rise flagged", int'(acqErr), 1);
    for (int p = 0; p < 12; p++) begin
      if (p == 5) begin
        cnvStN = 0;
        repeat (ACQ + REF) @(negedge clk);
        cnvStN = 1;
        @(negedge clk);
        @(negedge clk);
        pulse(1, 8);        // trigger while converting (R11)
      end else begin
        pulse(ACQ + REF, 8);
      end
      if (p == 2) begin
        csN = 0; @(negedge clk); csN = 1; @(negedge clk);
      end
    end
    chk("R6 first average", int'(fifoRdData), (logD[0] + logD[1] + logD[2] + logD[3]) >> 2);
    drain();

    // overflow: fill four words, then one more
    doCmd(4'b1111, 0, 0, 3);
    for (int p = 0; p < 4; p++) pulse(ACQ, 8);
    doCmd(4'b0001, 0, 0, 3);
    pulse(ACQ, 8);
    chk("R10 overflow flagged", int'(ovfErr), 1);
    drain();

    // 32-sample average, then an unused select code
    doCmd(4'b1000, 4, 0, 1);
    for (int p = 0; p < 32; p++) pulse(ACQ, 8);
    drain();
    doCmd(4'b0100, 7, 0, 1);
    pulse(ACQ, 8);
    chk("R6 unused code means one sample", int'(scanDone), 1);
    drain();

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule